// File: doc/BRIEF.md
# Half-step buffered PWM timer

This block is a 16-bit pulse-width timer meant to act as an audio DAC once its output is passed through an external low-pass filter. A free-running counter sweeps from zero up to a period compare value and then restarts. The output is high while the count lies between a duty compare value and the period compare value. Software writes one new audio sample into the duty compare register for every sample period. When buffering is on, the new sample waits and takes over only at the next period boundary, so the period in progress is never cut short.

A fine mode doubles the timing resolution. The lowest bit of each compare value then selects a half-clock step. The counter runs at half the count and compares only the upper bits. A register clocked on the falling edge, together with a clock-phase multiplexer, places each edge on either half of the counter clock. With a 40 MHz counter clock, pulse edges therefore land on a 12.5 ns grid. Separate control bits select output inversion, gate the waveform onto the pin, and start or stop counting.

Top module: `hpwm_timer`

## Requirements
- R1: After reset the pin is 0, the counter is 0, and the compare registers and every control bit are 0.
- R2: In normal mode with run set, the counter steps 0,1,…,B and returns to 0 on the next clock, so one period lasts B+1 clocks.
- R3: In normal mode the non-inverted level is high during exactly those clocks whose count c satisfies A ≤ c < B. That gives B−A high clocks per period, and each period starts low when A > 0.
- R4: With buffering enabled (control bit 2 = 1), a write to A may arrive at any point in a period. It changes nothing until the counter next returns to 0, and from that period on the new value applies.
- R5: With buffering disabled, a write to A applies to the comparison from the next clock onward.
- R6: When the active A is greater than or equal to B, the output level stays low for the whole period (0 % duty).
- R7: In fine mode (control bit 1 = 1), time runs in half-clock steps t = 2c or 2c+1. The counter wraps after count B>>1, so a period is 2·(B>>1)+2 half-steps. The level is high during half-steps with A ≤ t < B. The low half of the clock carries step 2c+1 and the high half carries step 2c, each one clock after the count.
- R8: With inversion set (control bit 3 = 1) and the output enabled, the pin is the exact complement of the non-inverted waveform in both halves of every clock, in both modes.
- R9: With output enable clear (control bit 4 = 0), the pin is 0.
- R10: With run clear (control bit 0 = 0), the counter holds at 0, the level is low, and the active A and B track the written values. Setting run then starts a fresh period at count 0.
- R11: A write to B takes effect only at the next period boundary, whatever the buffer setting.
- R12: Register writes: with wr_en_i high, wr_sel_i = 0 writes A, 1 writes B, 2 writes control bits [4:0] = {out_en, invert, buffer_en, fine, run}, and 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock; its falling edge also drives the half-step register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (0 duty A, 1 period B, 2 control) |
| wr_data_i | input | 16 | Write data |
| pwm_o | output | 1 | PWM output pin |

## Verification
The bench builds the block with its default 16-bit counter and the half-step path enabled, so both normal and fine timing are reachable in one build. Small compare values such as 3 and 9 keep periods to a few clocks. That brings odd and even compare bits, A ≥ B, mid-period writes and restarts within reach of a short run. A full 10-bit audio setting with B = 0x3FF and A moving between 0x200 and 0x100 checks long periods and the buffered sample hand-over. The reference model compares the pin in both clock phases on every cycle.

// File: rtl/hpwm_pkg.sv
`timescale 1ns/1ps
package hpwm_pkg;
  localparam int CTRL_W = 5;

  typedef enum logic [1:0] {
    SEL_CMP_A = 2'd0,
    SEL_CMP_B = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } wr_sel_e;

  // bit 0 run, 1 fine, 2 buf_en, 3 invert, 4 out_en
  typedef struct packed {
    logic out_en;
    logic invert;
    logic buf_en;
    logic fine;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/hpwm_regs.sv
`timescale 1ns/1ps
module hpwm_regs
  import hpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             wrap_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] a_eff_o,
  output logic [CNT_W-1:0] a_act_o,
  output logic [CNT_W-1:0] b_act_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] a_buf_q, a_act_q, b_buf_q, b_act_q;
  wr_sel_e          sel;
  logic             load;

  assign sel  = wr_sel_e'(wr_sel_i);
  assign load = wrap_i || !ctrl_q.run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      a_buf_q <= '0;
      b_buf_q <= '0;
    end else if (wr_en_i) begin
      case (sel)
        SEL_CMP_A: a_buf_q <= wr_data_i;
        SEL_CMP_B: b_buf_q <= wr_data_i;
        SEL_CTRL:  ctrl_q  <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        default:   ;
      endcase
    end
  end

  // active copies follow the buffers at period end or while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_act_q <= '0;
      b_act_q <= '0;
    end else if (load) begin
      a_act_q <= a_buf_q;
      b_act_q <= b_buf_q;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign a_eff_o = ctrl_q.buf_en ? a_act_q : a_buf_q;
  assign a_act_o = a_act_q;
  assign b_act_o = b_act_q;
endmodule

// File: rtl/hpwm_counter.sv
`timescale 1ns/1ps
module hpwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             fine_i,
  input  logic [CNT_W-1:0] b_act_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] b_end_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign b_end_o = fine_i ? {1'b0, b_act_i[CNT_W-1:1]} : b_act_i;
  assign wrap_o  = run_i && (cnt_q == b_end_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || wrap_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hpwm_edge.sv
`timescale 1ns/1ps
module hpwm_edge #(
  parameter int CNT_W        = 16,
  parameter bit HALF_STEP_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             fine_i,
  input  logic             invert_i,
  input  logic             out_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] a_i,
  input  logic [CNT_W-1:0] b_i,
  output logic             lvl_first_o,
  output logic             pwm_o
);
  localparam int TW = CNT_W + 1;

  logic [TW-1:0] t_first, t_second, a_w, b_w;
  logic          hi_first, hi_second;
  logic          first_q, second_q, lvl;

  assign a_w      = {1'b0, a_i};
  assign b_w      = {1'b0, b_i};
  assign t_first  = fine_i ? {cnt_i, 1'b0} : {1'b0, cnt_i};
  assign t_second = fine_i ? {cnt_i, 1'b1} : {1'b0, cnt_i};
  assign hi_first  = run_i && (t_first  >= a_w) && (t_first  < b_w);
  assign hi_second = run_i && (t_second >= a_w) && (t_second < b_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q  <= 1'b0;
      second_q <= 1'b0;
    end else begin
      first_q  <= hi_first;
      second_q <= hi_second;
    end
  end

  generate
    if (HALF_STEP_EN) begin : g_half
      logic neg_q;
      // second half-step shown while clk is low
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) neg_q <= 1'b0;
        else         neg_q <= second_q;
      end
      assign lvl = clk_i ? first_q : neg_q;
    end else begin : g_whole
      logic unused_second;
      assign unused_second = second_q;
      assign lvl = first_q;
    end
  endgenerate

  assign lvl_first_o = first_q;
  assign pwm_o       = out_en_i & (lvl ^ invert_i);
endmodule

// File: rtl/hpwm_timer.sv
`timescale 1ns/1ps
module hpwm_timer
  import hpwm_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter bit HALF_STEP_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] a_eff, a_act, b_act, cnt, b_end;
  logic             wrap, lvl_first;

  hpwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .wrap_i (wrap),
    .ctrl_o (ctrl),
    .a_eff_o(a_eff),
    .a_act_o(a_act),
    .b_act_o(b_act)
  );

  hpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .run_i  (ctrl.run),
    .fine_i (ctrl.fine),
    .b_act_i(b_act),
    .cnt_o  (cnt),
    .b_end_o(b_end),
    .wrap_o (wrap)
  );

  hpwm_edge #(.CNT_W(CNT_W), .HALF_STEP_EN(HALF_STEP_EN)) u_edge (
    .clk_i, .rst_ni,
    .run_i      (ctrl.run),
    .fine_i     (ctrl.fine),
    .invert_i   (ctrl.invert),
    .out_en_i   (ctrl.out_en),
    .cnt_i      (cnt),
    .a_i        (a_eff),
    .b_i        (b_act),
    .lvl_first_o(lvl_first),
    .pwm_o
  );
endmodule

// File: rtl/hpwm_timer_checker.sv
`timescale 1ns/1ps
module hpwm_timer_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run,
  input logic             buf_en,
  input logic             out_en,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] b_end,
  input logic [CNT_W-1:0] a_eff,
  input logic [CNT_W-1:0] a_act,
  input logic [CNT_W-1:0] b_act,
  input logic             lvl_first,
  input logic             pwm_o
);
  assert_count_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cnt == b_end) |=> (cnt == '0));

  assert_buffer_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && buf_en && !wrap) |=> $stable(a_act));

  assert_zero_duty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && a_eff >= b_act) |=> !lvl_first);

  assert_pin_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en |-> !pwm_o);

  assert_stopped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (cnt == '0 && !lvl_first));

  assert_period_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !wrap) |=> $stable(b_act));
endmodule

bind hpwm_timer hpwm_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni,
  .run      (ctrl.run),
  .buf_en   (ctrl.buf_en),
  .out_en   (ctrl.out_en),
  .wrap     (wrap),
  .cnt      (cnt),
  .b_end    (b_end),
  .a_eff    (a_eff),
  .a_act    (a_act),
  .b_act    (b_act),
  .lvl_first(lvl_first),
  .pwm_o    (pwm_o)
);

// File: tb/hpwm_timer_test.sv
`timescale 1ns/1ps
module hpwm_timer_test;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [1:0]   wr_sel_i = 2'd0;
  logic [W-1:0] wr_data_i = '0;
  logic         pwm_o;

  int n_checks = 0, n_errors = 0;
  bit done = 0, model_on = 0;
  string cur_req = "R1";

  always #5 clk_i = ~clk_i;

  hpwm_timer #(.CNT_W(W)) uut (.*);

  // behavioural reference
  int m_cnt = 0, m_abuf = 0, m_aact = 0, m_bbuf = 0, m_bact = 0;
  bit m_run = 0, m_fine = 0, m_buf = 0, m_inv = 0, m_oe = 0;
  bit m_first = 0, m_second = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_cnt = 0; m_abuf = 0; m_aact = 0; m_bbuf = 0; m_bact = 0;
      {m_run, m_fine, m_buf, m_inv, m_oe} = '0;
      m_first = 0; m_second = 0;
    end else begin
      int aeff, bend, t0, t1, ncnt;
      bit nf, ns, wrapv;
      aeff  = m_buf ? m_aact : m_abuf;
      bend  = m_fine ? (m_bact / 2) : m_bact;
      t0    = m_fine ? 2 * m_cnt : m_cnt;
      t1    = m_fine ? 2 * m_cnt + 1 : m_cnt;
      nf    = m_run && t0 >= aeff && t0 < m_bact;
      ns    = m_run && t1 >= aeff && t1 < m_bact;
      wrapv = m_run && m_cnt == bend;
      ncnt  = (!m_run || wrapv) ? 0 : (m_cnt + 1) % 65536;
      if (wrapv || !m_run) begin
        m_aact = m_abuf;
        m_bact = m_bbuf;
      end
      if (wr_en_i) begin
        case (wr_sel_i)
          2'd0: m_abuf = wr_data_i;
          2'd1: m_bbuf = wr_data_i;
          2'd2: begin
            m_run = wr_data_i[0]; m_fine = wr_data_i[1]; m_buf = wr_data_i[2];
            m_inv = wr_data_i[3]; m_oe = wr_data_i[4];
          end
          default: ;
        endcase
      end
      m_cnt = ncnt; m_first = nf; m_second = ns;
    end
    #2;
    if (model_on) chk({cur_req, " high phase"}, pwm_o, m_oe & (m_first ^ m_inv));
  end

  always @(negedge clk_i) begin
    #3;
    if (model_on) chk({cur_req, " low phase"}, pwm_o, m_oe & (m_second ^ m_inv));
  end

  // R12: sel 0 = A, 1 = B, 2 = ctrl {out_en, invert, buf_en, fine, run}
  task automatic wr(input logic [1:0] sel, input int data);
    @(negedge clk_i); #1;
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = W'(data);
    @(negedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic cfg(input int a, input int b, input int ctrl);
    wr(2'd2, ctrl & 'h1e);
    wr(2'd0, a);
    wr(2'd1, b);
    wr(2'd2, ctrl);
  endtask

  // counts high samples, two per clock (one per phase)
  task automatic meas(input int n, output int h);
    h = 0;
    repeat (n) begin
      @(posedge clk_i); #2; if (pwm_o) h++;
      @(negedge clk_i); #3; if (pwm_o) h++;
    end
  endtask

  localparam int RUN = 1, FINE = 2, BUF = 4, INV = 8, OE = 16;

  initial begin
    int h;
    repeat (3) @(negedge clk_i);
    cur_req = "R1";
    chk("R1 pin in reset", pwm_o, 0);
    #1 rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 pin after reset", pwm_o, 0);
    model_on = 1;

    cur_req = "R12";
    wr(2'd3, 'h1f);                      // ignored select
    repeat (3) @(negedge clk_i);
    chk("R12 sel 3 ignored", pwm_o, 0);

    cur_req = "R3";
    cfg(3, 9, RUN | BUF | OE);
    repeat (12) @(negedge clk_i);
    meas(30, h);
    chk("R2 R3 normal A=3 B=9", h, 36);

    cur_req = "R10";
    cfg(3, 9, BUF | OE);
    repeat (2) @(negedge clk_i);
    meas(20, h);
    chk("R10 stopped pin low", h, 0);

    cur_req = "R6";
    cfg(9, 9, RUN | BUF | OE);
    repeat (12) @(negedge clk_i);
    meas(30, h);
    chk("R6 A equal B", h, 0);
    cfg(12, 9, RUN | BUF | OE);
    repeat (12) @(negedge clk_i);
    meas(30, h);
    chk("R6 A above B", h, 0);

    cur_req = "R7";
    cfg(3, 10, RUN | FINE | BUF | OE);
    repeat (8) @(negedge clk_i);
    meas(18, h);
    chk("R7 fine A=3 B=10", h, 21);
    cfg(4, 11, RUN | FINE | BUF | OE);
    repeat (8) @(negedge clk_i);
    meas(18, h);
    chk("R7 fine A=4 B=11", h, 21);
    cfg(3, 9, RUN | FINE | BUF | OE);
    repeat (8) @(negedge clk_i);
    meas(15, h);
    chk("R7 fine A=3 B=9", h, 18);

    cur_req = "R8";
    cfg(3, 9, RUN | BUF | INV | OE);
    repeat (12) @(negedge clk_i);
    meas(30, h);
    chk("R8 inverted normal", h, 24);
    cfg(3, 9, RUN | FINE | BUF | INV | OE);
    repeat (8) @(negedge clk_i);
    meas(15, h);
    chk("R8 inverted fine", h, 12);

    cur_req = "R9";
    cfg(3, 9, RUN | BUF | INV);
    repeat (12) @(negedge clk_i);
    meas(30, h);
    chk("R9 output disabled", h, 0);

    cur_req = "R5";
    cfg(3, 9, RUN | OE);
    repeat (14) @(negedge clk_i);
    wr(2'd0, 6);
    repeat (4) @(negedge clk_i);
    meas(30, h);
    chk("R5 unbuffered new A", h, 18);

    cur_req = "R11";
    cfg(2, 9, RUN | BUF | OE);
    repeat (13) @(negedge clk_i);
    wr(2'd1, 5);
    repeat (14) @(negedge clk_i);
    meas(30, h);
    chk("R11 new period B=5", h, 30);

    cur_req = "R4";
    cfg('h200, 'h3ff, RUN | BUF | OE);
    repeat (1030) @(negedge clk_i);
    meas(2048, h);
    chk("R4 audio mid-scale", h, 2044);
    repeat (300) @(negedge clk_i);
    wr(2'd0, 'h100);
    repeat (1100) @(negedge clk_i);
    meas(2048, h);
    chk("R4 audio after sample 0x100", h, 3068);
    wr(2'd0, 'h300);
    repeat (1100) @(negedge clk_i);
    meas(2048, h);
    chk("R4 audio after sample 0x300", h, 1020);

    model_on = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule